// File: doc/BRIEF.md
# Translation-Buffer Pointer and Tag-Target Read Unit

This block sits beside a software-managed translation lookaside buffer and answers the two register reads a miss handler needs first. The first is the tag-target word, which repacks the captured faulting address and its context into the form used to compare against buffer entries. The second is a ready-made pointer into the in-memory translation storage buffer for one of two page-size slots. Software loads a tag-access register, four storage-buffer base registers and two configuration registers through a plain write port. It then issues reads on a valid/ready request channel and collects the answer one cycle later on a valid/ready response channel.

Each base register holds the buffer base in bits 63:13, the buffer size code in bits 3:0 and, for slot 1, a split flag in bit 12. Each configuration register holds a page-size code in bits 2:0. Each slot has one base register for context zero and one for all other contexts. The configuration registers are banked by context class in the same way, but both slots share them. The context field of the tag-access register picks the bank.

Back-pressure rules: a request is taken on a cycle where `rd_valid` and `rd_ready` are both high. `rd_ready` is high whenever the response register is empty or is being drained in that cycle (`rsp_ready` high). A pending response keeps its data and error flag unchanged until `rsp_ready` is seen high. The requester must hold `rd_sel` steady while `rd_valid` waits for `rd_ready`.

Top module: `tsb_ptr_gen`

## Requirements
- R1: After reset every register reads as zero, `rsp_valid` is low and `rd_ready` is high. Reads of all three selectors then return zero.
- R2: A write with `wr_en` high stores `wr_data` into the register named by `wr_idx`: 0 tag access, 1 slot-0 base for context zero, 2 slot-0 base for other contexts, 3 slot-1 base for context zero, 4 slot-1 base for other contexts, 5 config for context zero, 6 config for other contexts. A write with index 7 changes nothing.
- R3: A request taken at a clock edge produces `rsp_valid` high after that edge. `rd_ready` is low only while a response is pending and `rsp_ready` is low.
- R4: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data` and `rsp_err` stay unchanged.
- R5: Selector 0 returns tag-access bits 63:22 in result bits 41:0, ORed with tag-access bits 12:0 placed at result bits 60:48.
- R6: When tag-access bits 12:0 are all zero, pointers use the context-zero base and config registers. Otherwise they use the other-context set.
- R7: A pointer (selector 1 for slot 0, selector 2 for slot 1) keeps the selected base bits 63:13 in place, with bits 12:0 cleared before the index is merged.
- R8: The index is the tag-access value shifted right by 9 + 3·p, where p is config bits 2:0 (0 to 7).
- R9: The index is masked to bits 4 through 12 + s inclusive, where s is base bits 3:0 (0 to 15), and ORed into the pointer. Pointer bits 3:0 are always zero.
- R10: For slot 1 only, a set base bit 12 also sets pointer bit 13 + s. Bit 12 of a slot-0 base has no effect.
- R11: Both slots read the same config register for a given context class.
- R12: Selector 3 returns data zero with `rsp_err` high. Selectors 0 to 2 return `rsp_err` low.
- R13: A request taken in the same cycle as a write is answered from the register values held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Register index for the write |
| wr_data | input | 64 | Write data |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request can be taken |
| rd_sel | input | 2 | Read selector: 0 tag target, 1 slot-0 pointer, 2 slot-1 pointer |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 64 | Response data |
| rsp_err | output | 1 | Selector was not recognised |

## Verification
The assertions assume that the requester obeys the back-pressure rules: it keeps `rd_sel` steady while a request waits, and it does not expect an answer from a request that was never taken. Under that assumption, a held response cannot change and every taken request leads to a response. The stimulus drives all inputs on the falling edge, raises `rd_valid` only while it is watching `rd_ready`, and changes `rd_sel` only after it has seen the request taken. Config registers keep only the page-size field, so the bench writes arbitrary upper bits there. It then checks that pointers depend only on bits 2:0.

// File: rtl/tsbp_pkg.sv
package tsbp_pkg;
  localparam int DW         = 64;
  localparam int CTX_W      = 13;
  localparam int TT_LSB     = 22;
  localparam int CTX_POS    = 48;
  localparam int BASE_LSB   = 13;
  localparam int SPLIT_BIT  = 12;
  localparam int TSZ_W      = 4;
  localparam int PS_W       = 3;
  localparam int IDX_LSB    = 4;
  localparam int SHIFT_BASE = 9;
  localparam int SHIFT_STEP = 3;
  localparam int NSLOT      = 2;
  localparam int IDX_W      = 3;
  localparam int SEL_W      = 2;
  localparam int SH_W  = $clog2(SHIFT_BASE + SHIFT_STEP * ((1 << PS_W) - 1) + 1);
  localparam int TOP_W = $clog2(BASE_LSB + (1 << TSZ_W) + 1);

  localparam logic [IDX_W-1:0] RI_TAG    = 3'd0;
  localparam logic [IDX_W-1:0] RI_B0_C0  = 3'd1;
  localparam logic [IDX_W-1:0] RI_B0_CN  = 3'd2;
  localparam logic [IDX_W-1:0] RI_B1_C0  = 3'd3;
  localparam logic [IDX_W-1:0] RI_B1_CN  = 3'd4;
  localparam logic [IDX_W-1:0] RI_CFG_C0 = 3'd5;
  localparam logic [IDX_W-1:0] RI_CFG_CN = 3'd6;

  localparam logic [SEL_W-1:0] SEL_TT = 2'd0;
  localparam logic [SEL_W-1:0] SEL_P0 = 2'd1;
  localparam logic [SEL_W-1:0] SEL_P1 = 2'd2;

  typedef struct packed {
    logic [DW-1:0]             tag_acc;
    logic [NSLOT-1:0][DW-1:0]  base_c0;
    logic [NSLOT-1:0][DW-1:0]  base_cn;
    logic [PS_W-1:0]           cfg_c0;
    logic [PS_W-1:0]           cfg_cn;
  } tsbp_regs_t;
endpackage

// File: rtl/tsbp_regbank.sv
module tsbp_regbank
  import tsbp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  output tsbp_regs_t       regs
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (wr_en) begin
      case (wr_idx)
        RI_TAG:    regs.tag_acc    <= wr_data;
        RI_B0_C0:  regs.base_c0[0] <= wr_data;
        RI_B0_CN:  regs.base_cn[0] <= wr_data;
        RI_B1_C0:  regs.base_c0[1] <= wr_data;
        RI_B1_CN:  regs.base_cn[1] <= wr_data;
        RI_CFG_C0: regs.cfg_c0     <= wr_data[PS_W-1:0];
        RI_CFG_CN: regs.cfg_cn     <= wr_data[PS_W-1:0];
        default: ;
      endcase
    end
  end

  // R2
  tag_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_idx == RI_TAG |=> regs.tag_acc == $past(wr_data));
  // R2
  idx7_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_idx == 3'd7 |=> regs == $past(regs));
endmodule

// File: rtl/tsbp_ptr_calc.sv
module tsbp_ptr_calc
  import tsbp_pkg::*;
#(
  parameter bit SPLIT_EN = 1'b0
)(
  input  logic [DW-1:0]   tag_acc,
  input  logic [DW-1:0]   base,
  input  logic [PS_W-1:0] page_sz,
  output logic [DW-1:0]   ptr
);
  logic [SH_W-1:0]  shamt;
  logic [TOP_W-1:0] top;
  logic [DW-1:0]    idx, mask, base_part, merged;

  always_comb begin
    shamt     = SH_W'(SHIFT_BASE) + SH_W'(page_sz) * SH_W'(SHIFT_STEP);
    top       = TOP_W'(BASE_LSB) + TOP_W'(base[TSZ_W-1:0]);
    idx       = tag_acc >> shamt;
    mask      = ~({DW{1'b1}} << top) & ({DW{1'b1}} << IDX_LSB);
    base_part = base & ({DW{1'b1}} << BASE_LSB);
    merged    = base_part | (idx & mask);
  end

  generate
    if (SPLIT_EN) begin : g_split
      assign ptr = merged | (base[SPLIT_BIT] ? (DW'(1) << top) : '0);
    end else begin : g_plain
      assign ptr = merged;
    end
  endgenerate
endmodule

// File: rtl/tsb_ptr_gen.sv
module tsb_ptr_gen
  import tsbp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_idx,
  input  logic [63:0]      wr_data,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [1:0]       rd_sel,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [63:0]      rsp_data,
  output logic             rsp_err
);
  tsbp_regs_t          regs;
  logic                ctx_nz;
  logic [PS_W-1:0]     cfg_sel;
  logic [NSLOT-1:0][DW-1:0] base_sel;
  logic [NSLOT-1:0][DW-1:0] ptr;
  logic [DW-1:0]       tag_tgt;
  logic [DW-1:0]       nxt_data;
  logic                nxt_err;
  logic                take;

  tsbp_regbank u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs(regs)
  );

  assign ctx_nz  = |regs.tag_acc[CTX_W-1:0];
  assign cfg_sel = ctx_nz ? regs.cfg_cn : regs.cfg_c0;

  generate
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      assign base_sel[s] = ctx_nz ? regs.base_cn[s] : regs.base_c0[s];
      tsbp_ptr_calc #(.SPLIT_EN(s == 1)) u_calc (
        .tag_acc(regs.tag_acc), .base(base_sel[s]),
        .page_sz(cfg_sel), .ptr(ptr[s])
      );
    end
  endgenerate

  assign tag_tgt = DW'(regs.tag_acc[DW-1:TT_LSB])
                 | (DW'(regs.tag_acc[CTX_W-1:0]) << CTX_POS);

  always_comb begin
    nxt_err  = 1'b0;
    case (rd_sel)
      SEL_TT:  nxt_data = tag_tgt;
      SEL_P0:  nxt_data = ptr[0];
      SEL_P1:  nxt_data = ptr[1];
      default: begin
        nxt_data = '0;
        nxt_err  = 1'b1;
      end
    endcase
  end

  assign rd_ready = !rsp_valid || rsp_ready;
  assign take     = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_data  <= nxt_data;
      rsp_err   <= nxt_err;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R3
  take_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=> rsp_valid);
  // R4
  hold_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_err));
  // R12
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_data == '0);
  // R9
  ptr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr[0][IDX_LSB-1:0] == '0 && ptr[1][IDX_LSB-1:0] == '0);
  // R7
  ptr_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr[0][DW-1:BASE_LSB+(1<<TSZ_W)+1] == base_sel[0][DW-1:BASE_LSB+(1<<TSZ_W)+1]);
endmodule

// File: tb/test_tsb_ptr_gen.sv
module test_tsb_ptr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [1:0]  rd_sel = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_data;
  logic        rsp_err;

  int total = 0;
  int bad = 0;

  logic [63:0] m_tag;
  logic [63:0] m_base [2][2];
  logic [2:0]  m_cfg [2];

  always #4 clk = ~clk;

  tsb_ptr_gen i_tsb_ptr_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_sel(rd_sel),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_tt(logic [63:0] t);
    logic [63:0] r = '0;
    for (int b = 22; b < 64; b++) r[b-22] = t[b];
    for (int b = 0; b < 13; b++) r[48+b] = t[b];
    return r;
  endfunction

  function automatic logic [63:0] ref_ptr(int slot);
    int cls = (m_tag[12:0] == 0) ? 0 : 1;
    logic [63:0] bs = m_base[slot][cls];
    int sh = 9 + 3 * int'(m_cfg[cls]);
    int sz = int'(bs[3:0]);
    logic [63:0] r = '0;
    for (int b = 13; b < 64; b++) r[b] = bs[b];
    for (int b = 4; b <= 12 + sz; b++)
      if (b + sh < 64 && m_tag[b + sh]) r[b] = 1'b1;
    if (slot == 1 && bs[12]) r[13 + sz] = 1'b1;
    return r;
  endfunction

  task automatic wr(logic [2:0] idx, logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (idx)
      3'd0: m_tag = d;
      3'd1: m_base[0][0] = d;
      3'd2: m_base[0][1] = d;
      3'd3: m_base[1][0] = d;
      3'd4: m_base[1][1] = d;
      3'd5: m_cfg[0] = d[2:0];
      3'd6: m_cfg[1] = d[2:0];
      default: ;
    endcase
  endtask

  task automatic rd(string req, logic [1:0] sel, logic [63:0] exp, logic exp_err);
    @(negedge clk);
    rsp_ready = 1'b1; rd_valid = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_valid = 1'b0;
    chk({req, " valid"}, 64'(rsp_valid), 64'd1);
    chk({req, " data"}, rsp_data, exp);
    chk({req, " err"}, 64'(rsp_err), 64'(exp_err));
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 rd_ready", 64'(rd_ready), 64'd1);
    rd("R1 tt", 2'd0, 64'd0, 1'b0);
    rd("R1 p0", 2'd1, 64'd0, 1'b0);
    rd("R1 p1", 2'd2, 64'd0, 1'b0);
  endtask

  task automatic t_tagtgt;
    wr(3'd0, 64'hDEAD_BEEF_CAFE_1234);
    rd("R5 tt ctx nz", 2'd0, ref_tt(m_tag), 1'b0);
    wr(3'd0, 64'hFFFF_FFFF_FFC0_0000);
    rd("R5 tt ctx 0", 2'd0, ref_tt(m_tag), 1'b0);
  endtask

  task automatic t_banks;
    wr(3'd1, 64'h0000_1234_5678_E005);
    wr(3'd2, 64'h0000_00AB_CDEF_0003);
    wr(3'd5, 64'hFFFF_FFFF_FFFF_FFF8);
    wr(3'd6, 64'h0000_0000_0000_0001);
    wr(3'd0, 64'h0123_4567_89AB_C000);
    rd("R6 R7 p0 ctx0", 2'd1, ref_ptr(0), 1'b0);
    wr(3'd0, 64'h0123_4567_89AB_C0A5);
    rd("R6 R8 p0 ctxn", 2'd1, ref_ptr(0), 1'b0);
  endtask

  task automatic t_sizes;
    wr(3'd0, 64'hA5A5_5A5A_F0F0_0F0F);
    for (int k = 0; k < 8; k++) begin
      wr(3'd6, 64'(k));
      wr(3'd2, 64'hFEDC_BA98_7654_0000 | 64'(k * 2));
      rd("R8 R9 sweep", 2'd1, ref_ptr(0), 1'b0);
    end
    wr(3'd6, 64'd7);
    wr(3'd2, 64'h8000_0000_0000_000F);
    rd("R9 max size max page", 2'd1, ref_ptr(0), 1'b0);
    wr(3'd6, 64'd0);
    wr(3'd2, 64'hFFFF_FFFF_FFFF_E00F);
    rd("R9 max size min page", 2'd1, ref_ptr(0), 1'b0);
  endtask

  task automatic t_split;
    wr(3'd4, 64'h0000_0040_0000_1006);
    rd("R10 slot1 split", 2'd2, ref_ptr(1), 1'b0);
    chk("R10 bit set", 64'(rsp_data[19]), 64'd1);
    wr(3'd2, 64'h0000_0040_0000_1006);
    rd("R10 slot0 no split", 2'd1, ref_ptr(0), 1'b0);
  endtask

  task automatic t_shared;
    wr(3'd6, 64'd3);
    rd("R11 p0 cfg", 2'd1, ref_ptr(0), 1'b0);
    rd("R11 p1 cfg", 2'd2, ref_ptr(1), 1'b0);
    wr(3'd6, 64'd5);
    rd("R11 p1 cfg new", 2'd2, ref_ptr(1), 1'b0);
  endtask

  task automatic t_badsel;
    rd("R12 sel3", 2'd3, 64'd0, 1'b1);
    rd("R12 sel0 after", 2'd0, ref_tt(m_tag), 1'b0);
  endtask

  task automatic t_idx7;
    logic [63:0] t0, p0, p1;
    t0 = ref_tt(m_tag); p0 = ref_ptr(0); p1 = ref_ptr(1);
    wr(3'd7, 64'hFFFF_FFFF_FFFF_FFFF);
    rd("R2 idx7 tt", 2'd0, t0, 1'b0);
    rd("R2 idx7 p0", 2'd1, p0, 1'b0);
    rd("R2 idx7 p1", 2'd2, p1, 1'b0);
  endtask

  task automatic t_backpressure;
    logic [63:0] e0, e1;
    e0 = ref_tt(m_tag); e1 = ref_ptr(0);
    @(negedge clk);
    rsp_ready = 1'b0; rd_valid = 1'b1; rd_sel = 2'd0;
    @(negedge clk);
    rd_sel = 2'd1;
    chk("R3 first valid", 64'(rsp_valid), 64'd1);
    chk("R4 first data", rsp_data, e0);
    chk("R3 ready low", 64'(rd_ready), 64'd0);
    @(negedge clk);
    chk("R4 held valid", 64'(rsp_valid), 64'd1);
    chk("R4 held data", rsp_data, e0);
    rsp_ready = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    chk("R3 second data", rsp_data, e1);
    @(negedge clk);
    chk("R3 drained", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_samecycle;
    logic [63:0] old_tt;
    old_tt = ref_tt(m_tag);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd0; wr_data = 64'h1111_2222_3333_0444;
    rd_valid = 1'b1; rd_sel = 2'd0; rsp_ready = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_valid = 1'b0;
    m_tag = 64'h1111_2222_3333_0444;
    chk("R13 old value", rsp_data, old_tt);
    rd("R13 new value", 2'd0, ref_tt(m_tag), 1'b0);
  endtask

  initial begin
    m_tag = '0;
    m_cfg[0] = '0; m_cfg[1] = '0;
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++) m_base[a][b] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tagtgt();
    t_banks();
    t_sizes();
    t_split();
    t_shared();
    t_badsel();
    t_idx7();
    t_backpressure();
    t_samecycle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule